// File: doc/BRIEF.md
# Speculative Line Tracker with Snoop Violation Detection

This block tracks, for each line of a small direct-mapped cache, whether the running speculative transaction has read the line and whether it has written it. Other processors publish their finished transactions as commit packets. Each packet entry is presented on the snoop port either as an address alone, or as an address together with new line data. When such an address lands on a line the local transaction has read, the local transaction has consumed stale data. The block then pulses a violation output so the processor restarts. At the same time it discards every speculatively written line and forgets all read marks.

A local access presents a line address. The address's low bits select the line and the remaining bits form the tag. A read marks the line as read and refills it on a miss from the data supplied with the request. A store writes the line's data and marks it modified. The same port always reports, without delay, the hit status, both marks and the data of the line that the presented address selects. When the local transaction is allowed to commit, one cycle of the commit input turns every speculative line into an ordinary valid line. Within a cycle the block applies any snooped entry first, then the commit or rollback, then the local access.

Top module: `spec_line_tracker`

## Requirements
- R1: While reset is held and right after it, every line is invalid: loc_hit, loc_rbit and loc_mbit read 0, loc_rdata reads 0 and viol is 0.
- R2: A local read (loc_req=1, loc_write=0) sets the read mark of the addressed line. On a miss it installs the line with loc_data as fill data. On a hit it leaves the data unchanged.
- R3: A local store (loc_req=1, loc_write=1) leaves the addressed line valid and modified, holding loc_data.
- R4: A snooped entry whose address hits a valid line with its read mark set makes viol high in the cycle after the snoop, for that one cycle.
- R5: On a violation, every modified line becomes invalid and every read mark is cleared.
- R6: An address-only snooped entry (snp_has_data=0) that hits a line that is not modified invalidates that line. If the line's read mark is clear, no violation follows.
- R7: A snooped entry with data (snp_has_data=1) that hits a line that is not modified replaces the line's data and keeps the line valid.
- R8: A snooped entry that hits a modified line leaves that line's data, validity and marks unchanged, unless that same cycle raises a violation.
- R9: A tx_commit cycle without a violation clears all read and modified marks. All lines keep their validity and data.
- R10: After a violation, later snoops to lines read before that violation do not raise viol again until those lines are read anew.
- R11: When a snoop and a local access reach the same line in one cycle, the snoop is applied first and the local access acts on the result.
- R12: A tx_commit in the same cycle as a violating snoop has no effect: the rollback of R5 takes place instead.
- R13: A snooped address whose selected line is invalid or holds another tag changes nothing and raises no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_req | input | 1 | Local access request |
| loc_write | input | 1 | 1 = store, 0 = speculative read |
| loc_addr | input | ADDR_W | Local line address; low IDX_W bits select the line |
| loc_data | input | DATA_W | Store data, or refill data on a read miss |
| loc_hit | output | 1 | Line selected by loc_addr is valid with a matching tag |
| loc_rbit | output | 1 | Read mark of that line (0 on a miss) |
| loc_mbit | output | 1 | Modified mark of that line (0 on a miss) |
| loc_rdata | output | DATA_W | Data of that line (0 on a miss) |
| tx_commit | input | 1 | Local transaction commits this cycle |
| snp_valid | input | 1 | A snooped commit-packet entry is present |
| snp_has_data | input | 1 | 1 = entry carries data (update), 0 = address only (invalidate) |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_data | input | DATA_W | Snooped line data |
| viol | output | 1 | One-cycle violation pulse; the transaction must restart |

## Verification
A wrong read mark shows in one of two ways. A conflicting snoop may pass with viol silent, or a harmless snoop may pulse viol. Either shows at the clock edge after the snoop, and the lookup outputs expose the mark itself at once. A modified mark left standing after a rollback, or a line wrongly cleared by one, shows in loc_hit and loc_mbit at the very next lookup. The bench therefore probes a chosen line straight after every step. This also catches a snoop, commit and local-access ordering error within the cycle in which that error occurs.

// File: rtl/slt_pkg.sv
// Shared types for the speculative line tracker.
// Assumes: none; holds only type declarations.
package slt_pkg;

    // Per-line status: present, read by this transaction, written by it
    typedef struct packed {
        logic valid;
        logic rd;
        logic md;
    } line_flags_t;

    // What a snooped commit-packet entry asks of a hit line
    typedef enum logic [1:0] {
        SNP_NONE   = 2'd0,
        SNP_INVAL  = 2'd1,
        SNP_UPDATE = 2'd2
    } snp_act_t;

endpackage

// File: rtl/slt_line_slot.sv
// One cache line's tag, data and speculative marks.
// Applies, in one cycle and in this order: the snoop action, then rollback
// or commit clearing, then the local access.
// Assumes: snp_hit already includes index and tag match; rollback and
// commit_clr are never both high.
module slt_line_slot
    import slt_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_hit,
    input  snp_act_t          snp_act,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              rollback,
    input  logic              commit_clr,
    input  logic              loc_sel,
    input  logic              loc_write,
    input  logic [TAG_W-1:0]  loc_tag,
    input  logic [DATA_W-1:0] loc_data,
    output line_flags_t       flags_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o
);

    line_flags_t       flags_q, flags_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              now_hit;

    // Next-state: snoop first, then transaction end, then local access
    always_comb begin
        flags_d = flags_q;
        tag_d   = tag_q;
        data_d  = data_q;
        if (snp_hit && !flags_q.md) begin
            if (snp_act == SNP_UPDATE) begin
                data_d = snp_data;
            end else begin
                flags_d.valid = 1'b0;
            end
        end
        if (rollback) begin
            flags_d.rd = 1'b0;
            if (flags_d.md) begin
                flags_d.valid = 1'b0;
                flags_d.md    = 1'b0;
            end
        end else if (commit_clr) begin
            flags_d.rd = 1'b0;
            flags_d.md = 1'b0;
        end
        now_hit = flags_d.valid && (tag_d == loc_tag);
        if (loc_sel) begin
            if (!now_hit) begin
                flags_d.valid = 1'b1;
                flags_d.rd    = 1'b0;
                flags_d.md    = 1'b0;
                tag_d         = loc_tag;
                data_d        = loc_data;
            end
            if (loc_write) begin
                flags_d.md = 1'b1;
                data_d     = loc_data;
            end else begin
                flags_d.rd = 1'b1;
            end
        end
    end

    // Line state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            tag_q   <= '0;
            data_q  <= '0;
        end else begin
            flags_q <= flags_d;
            tag_q   <= tag_d;
            data_q  <= data_d;
        end
    end

    assign flags_o = flags_q;
    assign tag_o   = tag_q;
    assign data_o  = data_q;

endmodule

// File: rtl/slt_conflict_detect.sv
// Matches a snooped address against every line and flags a conflict when
// the hit line carries a read mark.
// Assumes: a snooped address can select at most one line (direct-mapped).
module slt_conflict_detect #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 5
) (
    input  logic                              snp_valid,
    input  logic [IDX_W-1:0]                  snp_idx,
    input  logic [TAG_W-1:0]                  snp_tag,
    input  logic [NUM_LINES-1:0]              vld_vec,
    input  logic [NUM_LINES-1:0]              rd_vec,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]   tags,
    output logic [NUM_LINES-1:0]              snp_hit_vec,
    output logic                              conflict
);

    // Per-line hit: snoop present, index selects it, valid, same tag
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_match
        localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(i);
        assign snp_hit_vec[i] = snp_valid && (snp_idx == SLOT_IDX)
                                && vld_vec[i] && (tags[i] == snp_tag);
    end

    // A hit on a line this transaction has read is a violation
    assign conflict = |(snp_hit_vec & rd_vec);

endmodule

// File: rtl/slt_lookup_mux.sv
// Reports the state of the line selected by the local address: hit, marks
// and data, all forced to 0 on a miss.
// Assumes: NUM_LINES equals 2**IDX_W.
module slt_lookup_mux #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 5,
    parameter int DATA_W    = 16
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [TAG_W-1:0]                 tag,
    input  logic [NUM_LINES-1:0]             vld_vec,
    input  logic [NUM_LINES-1:0]             rd_vec,
    input  logic [NUM_LINES-1:0]             md_vec,
    input  logic [NUM_LINES-1:0][TAG_W-1:0]  tags,
    input  logic [NUM_LINES-1:0][DATA_W-1:0] datas,
    output logic                             hit,
    output logic                             rbit,
    output logic                             mbit,
    output logic [DATA_W-1:0]                rdata
);

    // Select the indexed line and gate its state with the tag compare
    always_comb begin
        hit   = vld_vec[idx] && (tags[idx] == tag);
        rbit  = hit && rd_vec[idx];
        mbit  = hit && md_vec[idx];
        rdata = hit ? datas[idx] : '0;
    end

endmodule

// File: rtl/spec_line_tracker.sv
// Top of the speculative line tracker: per-line read and modified marks,
// snoop handling of commit-packet entries, violation pulse and rollback.
// Assumes: NUM_LINES is a power of two, at least 2; a local access never
// replaces a line that still carries a mark of another tag.
module spec_line_tracker
    import slt_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_req,
    input  logic              loc_write,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_data,
    output logic              loc_hit,
    output logic              loc_rbit,
    output logic              loc_mbit,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic              tx_commit,
    input  logic              snp_valid,
    input  logic              snp_has_data,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    output logic              viol
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]                 loc_idx, snp_idx;
    logic [TAG_W-1:0]                 loc_tag, snp_tag;
    logic [NUM_LINES-1:0]             vld_vec, rd_vec, md_vec, snp_hit_vec;
    logic [NUM_LINES-1:0][TAG_W-1:0]  tags;
    logic [NUM_LINES-1:0][DATA_W-1:0] datas;
    logic                             conflict, commit_clr;
    logic                             viol_q;
    snp_act_t                         snp_act;

    // Address split: low bits pick the line, the rest form the tag
    assign loc_idx = loc_addr[IDX_W-1:0];
    assign loc_tag = loc_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    // Snoop entry form: address-only invalidates, address+data updates
    always_comb begin
        if (!snp_valid)        snp_act = SNP_NONE;
        else if (snp_has_data) snp_act = SNP_UPDATE;
        else                   snp_act = SNP_INVAL;
    end

    slt_conflict_detect #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_conflict (
        .snp_valid   (snp_valid),
        .snp_idx     (snp_idx),
        .snp_tag     (snp_tag),
        .vld_vec     (vld_vec),
        .rd_vec      (rd_vec),
        .tags        (tags),
        .snp_hit_vec (snp_hit_vec),
        .conflict    (conflict)
    );

    // A violation in the same cycle overrides the local commit
    assign commit_clr = tx_commit && !conflict;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(i);
        line_flags_t flags;

        slt_line_slot #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .snp_hit    (snp_hit_vec[i]),
            .snp_act    (snp_act),
            .snp_data   (snp_data),
            .rollback   (conflict),
            .commit_clr (commit_clr),
            .loc_sel    (loc_req && (loc_idx == SLOT_IDX)),
            .loc_write  (loc_write),
            .loc_tag    (loc_tag),
            .loc_data   (loc_data),
            .flags_o    (flags),
            .tag_o      (tags[i]),
            .data_o     (datas[i])
        );

        assign vld_vec[i] = flags.valid;
        assign rd_vec[i]  = flags.rd;
        assign md_vec[i]  = flags.md;
    end

    slt_lookup_mux #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_lookup (
        .idx     (loc_idx),
        .tag     (loc_tag),
        .vld_vec (vld_vec),
        .rd_vec  (rd_vec),
        .md_vec  (md_vec),
        .tags    (tags),
        .datas   (datas),
        .hit     (loc_hit),
        .rbit    (loc_rbit),
        .mbit    (loc_mbit),
        .rdata   (loc_rdata)
    );

    // Violation pulse: registered copy of this cycle's conflict
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= conflict;
    end

    assign viol = viol_q;

endmodule

// File: rtl/slt_checker.sv
// Protocol checks for spec_line_tracker, attached by bind.
// Assumes: sees the line mark vectors of the tracker it is bound to.
module slt_checker #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 loc_req,
    input logic                 loc_write,
    input logic [IDX_W-1:0]     loc_idx,
    input logic                 snp_valid,
    input logic [IDX_W-1:0]     snp_idx,
    input logic                 tx_commit,
    input logic                 viol,
    input logic [NUM_LINES-1:0] vld_vec,
    input logic [NUM_LINES-1:0] rd_vec,
    input logic [NUM_LINES-1:0] md_vec
);

    logic [IDX_W-1:0] loc_idx_q;
    logic             snp_on_read_q;

    // Remember last cycle's local index and whether a snoop met a read line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_idx_q     <= '0;
            snp_on_read_q <= 1'b0;
        end else begin
            loc_idx_q     <= loc_idx;
            snp_on_read_q <= snp_valid && rd_vec[snp_idx];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (vld_vec == '0 && !viol)); // R1

    AST_READ_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_write) |=> rd_vec[loc_idx_q]); // R2

    AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && loc_write) |=> (md_vec[loc_idx_q] && vld_vec[loc_idx_q])); // R3

    AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> snp_on_read_q); // R4

    AST_ROLLBACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !$past(loc_req)) |-> (rd_vec == '0 && md_vec == '0)); // R5

    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_commit && !loc_req) |=> (rd_vec == '0 && md_vec == '0)); // R9

endmodule

bind spec_line_tracker slt_checker #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
) u_slt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_req   (loc_req),
    .loc_write (loc_write),
    .loc_idx   (loc_idx),
    .snp_valid (snp_valid),
    .snp_idx   (snp_idx),
    .tx_commit (tx_commit),
    .viol      (viol),
    .vld_vec   (vld_vec),
    .rd_vec    (rd_vec),
    .md_vec    (md_vec)
);

// File: tb/test_spec_line_tracker.sv
`timescale 1ns/100ps
// Bench for spec_line_tracker: a vector table walked by one loop, then
// directed tests for reset and same-cycle ordering corner cases.
module test_spec_line_tracker;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    // op: 0 idle, 1 local read, 2 local store, 3 commit
    // sop: 0 none, 1 address-only snoop, 2 snoop with data
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  la;
        logic [15:0] ld;
        logic [1:0]  sop;
        logic [7:0]  sa;
        logic [15:0] sd;
        logic        ev;
        logic [7:0]  pa;
        logic        eh;
        logic        er;
        logic        em;
        logic [15:0] ed;
        logic [3:0]  rq;
    } vec_t;

    // Lines: 8'h11 idx1, 8'h22 idx2, 8'h33 idx3, 8'h91 idx1 other tag
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h11, 16'h1111, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 16'h1111, 4'd2},  // R2 read miss fills
        '{2'd1, 8'h11, 16'h2222, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 16'h1111, 4'd2},  // R2 read hit keeps data
        '{2'd2, 8'h22, 16'hB0B0, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h22, 1'b1, 1'b0, 1'b1, 16'hB0B0, 4'd3},  // R3 store
        '{2'd0, 8'h00, 16'h0000, 2'd2, 8'h22, 16'h5555, 1'b0, 8'h22, 1'b1, 1'b0, 1'b1, 16'hB0B0, 4'd8},  // R8 modified line kept
        '{2'd0, 8'h00, 16'h0000, 2'd1, 8'h91, 16'h0000, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 16'h1111, 4'd13}, // R13 tag mismatch
        '{2'd3, 8'h00, 16'h0000, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0, 16'h1111, 4'd9},  // R9 commit clears read
        '{2'd0, 8'h00, 16'h0000, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h22, 1'b1, 1'b0, 1'b0, 16'hB0B0, 4'd9},  // R9 modified made plain
        '{2'd0, 8'h00, 16'h0000, 2'd2, 8'h11, 16'h7777, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0, 16'h7777, 4'd7},  // R7 update
        '{2'd0, 8'h00, 16'h0000, 2'd1, 8'h22, 16'h0000, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 invalidate
        '{2'd1, 8'h33, 16'h3333, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h33, 1'b1, 1'b1, 1'b0, 16'h3333, 4'd2},  // R2 read another line
        '{2'd2, 8'h11, 16'hAAAA, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h11, 1'b1, 1'b0, 1'b1, 16'hAAAA, 4'd3},  // R3 store hit
        '{2'd0, 8'h00, 16'h0000, 2'd1, 8'h33, 16'h0000, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd5},  // R4 R5 rollback drops store
        '{2'd0, 8'h00, 16'h0000, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd4},  // R4 pulse ends
        '{2'd1, 8'h33, 16'h4444, 2'd0, 8'h00, 16'h0000, 1'b0, 8'h33, 1'b1, 1'b1, 1'b0, 16'h4444, 4'd2},  // R2 refill
        '{2'd0, 8'h00, 16'h0000, 2'd2, 8'h33, 16'h9999, 1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 16'h9999, 4'd5},  // R5 read mark cleared
        '{2'd0, 8'h00, 16'h0000, 2'd2, 8'h33, 16'h8888, 1'b0, 8'h33, 1'b1, 1'b0, 1'b0, 16'h8888, 4'd10}  // R10 no second pulse
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              loc_req = 1'b0, loc_write = 1'b0;
    logic [ADDR_W-1:0] loc_addr = '0;
    logic [DATA_W-1:0] loc_data = '0;
    logic              loc_hit, loc_rbit, loc_mbit;
    logic [DATA_W-1:0] loc_rdata;
    logic              tx_commit = 1'b0;
    logic              snp_valid = 1'b0, snp_has_data = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [DATA_W-1:0] snp_data = '0;
    logic              viol;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    spec_line_tracker #(
        .NUM_LINES (8),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_spec_line_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .loc_req      (loc_req),
        .loc_write    (loc_write),
        .loc_addr     (loc_addr),
        .loc_data     (loc_data),
        .loc_hit      (loc_hit),
        .loc_rbit     (loc_rbit),
        .loc_mbit     (loc_mbit),
        .loc_rdata    (loc_rdata),
        .tx_commit    (tx_commit),
        .snp_valid    (snp_valid),
        .snp_has_data (snp_has_data),
        .snp_addr     (snp_addr),
        .snp_data     (snp_data),
        .viol         (viol)
    );

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // One clock step: drive at negedge, release inputs just after the edge
    task automatic step(input logic [1:0] op, input logic [7:0] la, input logic [15:0] ld,
                        input logic [1:0] sop, input logic [7:0] sa, input logic [15:0] sd);
        @(negedge clk);
        loc_req      = (op == 2'd1) || (op == 2'd2);
        loc_write    = (op == 2'd2);
        loc_addr     = la;
        loc_data     = ld;
        tx_commit    = (op == 2'd3);
        snp_valid    = (sop != 2'd0);
        snp_has_data = (sop == 2'd2);
        snp_addr     = sa;
        snp_data     = sd;
        @(posedge clk);
        #1;
        loc_req   = 1'b0;
        loc_write = 1'b0;
        tx_commit = 1'b0;
        snp_valid = 1'b0;
    endtask

    // Look up a line through the local port without requesting an access
    task automatic probe(input string rq, input logic [7:0] pa, input logic eh,
                         input logic er, input logic em, input logic [15:0] ed);
        loc_addr = pa;
        #1;
        check({rq, " hit"},   32'(loc_hit),   32'(eh));
        check({rq, " rbit"},  32'(loc_rbit),  32'(er));
        check({rq, " mbit"},  32'(loc_mbit),  32'(em));
        check({rq, " rdata"}, 32'(loc_rdata), 32'(ed));
    endtask

    initial begin
        // R1: state while reset is held
        repeat (3) @(posedge clk);
        #1;
        check("R1 viol in reset", 32'(viol), 32'd0);
        probe("R1", 8'h11, 1'b0, 1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (VECS[k]) begin
            vec_t v;
            string rq;
            v  = VECS[k];
            rq = $sformatf("R%0d vec%0d", v.rq, k);
            step(v.op, v.la, v.ld, v.sop, v.sa, v.sd);
            check({rq, " viol"}, 32'(viol), 32'(v.ev));
            probe(rq, v.pa, v.eh, v.er, v.em, v.ed);
        end

        // R11: snoop invalidate and local read of the same read line
        step(2'd1, 8'h11, 16'h1234, 2'd0, 8'h00, 16'h0000);
        step(2'd1, 8'h11, 16'h6666, 2'd1, 8'h11, 16'h0000);
        check("R11 viol", 32'(viol), 32'd1);
        probe("R11", 8'h11, 1'b1, 1'b1, 1'b0, 16'h6666);
        step(2'd3, 8'h00, 16'h0000, 2'd0, 8'h00, 16'h0000);
        check("R11 pulse ends", 32'(viol), 32'd0);

        // R12: commit in the cycle of a violating snoop is dropped
        step(2'd2, 8'h22, 16'hBBBB, 2'd0, 8'h00, 16'h0000);
        step(2'd1, 8'h33, 16'h0000, 2'd0, 8'h00, 16'h0000);
        @(negedge clk);
        tx_commit = 1'b1;
        snp_valid = 1'b1;
        snp_has_data = 1'b0;
        snp_addr = 8'h33;
        @(posedge clk);
        #1;
        tx_commit = 1'b0;
        snp_valid = 1'b0;
        check("R12 viol", 32'(viol), 32'd1);
        probe("R12 store rolled back", 8'h22, 1'b0, 1'b0, 1'b0, 16'h0000);

        // R11: snoop update and store to the same modified-free line
        step(2'd1, 8'h44, 16'h0404, 2'd0, 8'h00, 16'h0000);
        step(2'd3, 8'h00, 16'h0000, 2'd0, 8'h00, 16'h0000);
        step(2'd2, 8'h44, 16'hC0DE, 2'd2, 8'h44, 16'hDEAD);
        check("R11 store after update viol", 32'(viol), 32'd0);
        probe("R11 store wins", 8'h44, 1'b1, 1'b0, 1'b1, 16'hC0DE);

        // R1: reset in mid-run clears every line
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 viol after reset", 32'(viol), 32'd0);
        probe("R1 after reset", 8'h44, 1'b0, 1'b0, 1'b0, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule